// File: doc/BRIEF.md
# SMBus Target Block-Read Responder

This block is the target side of an SMBus controller. It works at byte level: a bit shifter that is not part of the block reports start and stop conditions. It passes each byte shifted in from the bus master and asks for the acknowledge decision on that byte. It also takes each byte this block returns during a read. Firmware stages up to 32 reply bytes. It then writes one configuration word: the 7-bit target address, the command code, the valid byte count and a PEC enable. That write arms the responder.

A master starts with a write to the armed address carrying the armed command. It then issues a repeated start and a read to the same address. The block answers that read in hardware. It returns the byte count, then the staged bytes in index order, then a CRC-8 packet error code if PEC is enabled. When the final byte has been taken, the responder disarms itself and raises a sticky done flag.

Every other byte the master writes goes to a 240-entry receive queue for firmware. This includes the address bytes. The address and command of a candidate block read are held back until the block knows whether a hardware read follows. A queue that cannot take another byte NACKs the byte and sets an overflow flag.

Top module: `smbus_blkrd_target`

## Requirements
- R1: After reset, `rd_ready`, `rd_done`, `rxq_ovf` and `rxq_level` are all 0.
- R2: A configuration write sets `rd_ready` and clears `rd_done`. A count above 32 is stored as 32.
- R3: A hardware block read is the following sequence: start, write address byte `{addr,0}` equal to the armed address, the armed command byte, repeated start, read address byte `{addr,1}`. The read address byte is ACKed. The bytes returned are the stored count, then staged bytes 0 to count-1.
- R4: With PEC enabled, one more byte follows the last data byte. It is the CRC-8 (polynomial 0x07, initial value 0, MSB first, no final XOR) over the write address byte, the command, the read address byte, the count and the data bytes.
- R5: A read address byte is NACKed in any of these cases: its address differs from the armed one, `rd_ready` is 0, or it is not directly preceded in the same transaction by a matching write address and command.
- R6: When the master takes the final byte (the last data byte, or the PEC byte when enabled), `rd_ready` clears and `rd_done` sets. If the master NACKs an earlier byte, `rd_ready` stays set.
- R7: Each byte of a write-direction transfer is ACKed and queued in arrival order while there is room. This includes the write address byte. The queue shows its head on `rxq_data`, and `rxq_pop` removes the head.
- R8: Neither the write address nor the command of an accepted hardware read is queued. When a matching address and command are instead followed by more data, a stop, or a start other than the read, both bytes are queued ahead of whatever follows.
- R9: A byte is NACKed and `rxq_ovf` set when the queued bytes plus the held bytes already total 240. The rest of that transaction is NACKed. `rxq_level` never exceeds 240, and a pop clears `rxq_ovf`.
- R10: After a NACKed byte, every further byte up to the next start or stop is NACKed and not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start or repeated start seen on the bus (one-cycle pulse) |
| bus_stop | input | 1 | Stop seen on the bus (one-cycle pulse) |
| rx_vld | input | 1 | A byte from the master is available on `rx_byte` |
| rx_byte | input | 8 | Byte shifted in from the master |
| rx_ack | output | 1 | ACK (1) or NACK (0) for the current `rx_byte`; valid while `rx_vld` |
| tx_byte | output | 8 | Byte to return in the next read slot |
| tx_take | input | 1 | The shifter has sent `tx_byte` (one-cycle pulse) |
| tx_mack | input | 1 | Master acknowledge after the byte sent with `tx_take` |
| buf_we | input | 1 | Write one staged reply byte |
| buf_idx | input | 5 | Index of the staged byte |
| buf_wdata | input | 8 | Staged byte value |
| cfg_we | input | 1 | Load the configuration and arm the responder |
| cfg_addr | input | 7 | Target address to answer |
| cfg_cmd | input | 8 | Command code to answer |
| cfg_cnt | input | 6 | Number of valid staged bytes |
| cfg_pec | input | 1 | Append a PEC byte to the reply |
| rd_ready | output | 1 | Responder armed |
| rd_done | output | 1 | Sticky: an armed reply has been sent completely |
| rxq_pop | input | 1 | Remove the head of the receive queue |
| rxq_data | output | 8 | Head of the receive queue |
| rxq_level | output | 8 | Number of bytes in the receive queue |
| rxq_ovf | output | 1 | Sticky: a byte was refused because the queue was full |

## Verification
The checker watches the acknowledge rules on every cycle. A full queue always refuses, and an accepted read address byte must carry the armed address while armed. It also checks that the count byte is offered right after a read is accepted, that done never rises while armed, that the overflow flag only rises on a refused byte, and that the queue grows by at most one per cycle and stays within bound. Whether the returned data, the PEC value and the queue contents are correct can be shown only by the bench scenarios. So can the deferred queuing of a candidate address and command, and the NACK of a read that lacks its write preamble. These scenarios cover random staged data, counts and transaction kinds, and compare every byte against a model.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    localparam logic [7:0] PEC_POLY = 8'h07;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CAND,
        ST_MATCH,
        ST_WDATA,
        ST_READ,
        ST_SKIP
    } smbt_state_e;

    typedef struct packed {
        logic [6:0] addr;
        logic [7:0] cmd;
        logic       pec;
    } smbt_cfg_t;

    function automatic logic [7:0] crc8_step(logic [7:0] crc, logic [7:0] din);
        logic [7:0] c;
        c = crc ^ din;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ PEC_POLY) : (c << 1);
        end
        return c;
    endfunction

    // PEC state after write address, command and read address bytes
    function automatic logic [7:0] pec_seed(logic [6:0] addr, logic [7:0] cmd);
        logic [7:0] c;
        c = crc8_step(8'h00, {addr, 1'b0});
        c = crc8_step(c, cmd);
        c = crc8_step(c, {addr, 1'b1});
        return c;
    endfunction

endpackage

// File: rtl/smbt_rx_fifo.sv
module smbt_rx_fifo #(
    parameter int DEPTH = 240,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    output logic [7:0]       pop_data,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign do_push  = push && (level != LVL_FULL);
    assign do_pop   = pop && (level != '0);
    assign pop_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/smbt_rdbuf.sv
module smbt_rdbuf #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[i] <= '0;
            else if (we && (widx == IDX_W'(i)))
                ent[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ridx == IDX_W'(i)) rdata = ent[i];
        end
    end
endmodule

// File: rtl/smbt_reply.sv
module smbt_reply
    import smbt_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             begin_rd,
    input  logic [7:0]       seed,
    input  logic [CNT_W-1:0] cnt,
    input  logic             pec_en,
    input  logic             take,
    input  logic             mack,
    input  logic [7:0]       buf_data,
    output logic [IDX_W-1:0] buf_idx,
    output logic [7:0]       tx_byte,
    output logic             finish,
    output logic             abort
);
    logic [CNT_W:0] pos;
    logic [CNT_W:0] last_pos;
    logic [CNT_W:0] cnt_x;
    logic [7:0]     crc_q;

    assign cnt_x    = {1'b0, cnt};
    assign last_pos = cnt_x + {{CNT_W{1'b0}}, pec_en};
    assign buf_idx  = IDX_W'(pos - 1'b1);

    always_comb begin
        if (pos == '0)
            tx_byte = 8'(cnt);
        else if (pos <= cnt_x)
            tx_byte = buf_data;
        else
            tx_byte = crc_q;
    end

    assign finish = take && (pos == last_pos);
    assign abort  = take && !mack && !finish;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            crc_q <= '0;
        end else if (begin_rd) begin
            pos   <= '0;
            crc_q <= seed;
        end else if (take) begin
            pos   <= pos + 1'b1;
            crc_q <= crc8_step(crc_q, tx_byte);
        end
    end
endmodule

// File: rtl/smbus_blkrd_target.sv
module smbus_blkrd_target
    import smbt_pkg::*;
#(
    parameter int RD_DEPTH  = 32,
    parameter int RXQ_DEPTH = 240,
    parameter int IDX_W     = $clog2(RD_DEPTH),
    parameter int CNT_W     = $clog2(RD_DEPTH + 1),
    parameter int LVL_W     = $clog2(RXQ_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             rx_vld,
    input  logic [7:0]       rx_byte,
    output logic             rx_ack,
    output logic [7:0]       tx_byte,
    input  logic             tx_take,
    input  logic             tx_mack,
    input  logic             buf_we,
    input  logic [IDX_W-1:0] buf_idx,
    input  logic [7:0]       buf_wdata,
    input  logic             cfg_we,
    input  logic [6:0]       cfg_addr,
    input  logic [7:0]       cfg_cmd,
    input  logic [CNT_W-1:0] cfg_cnt,
    input  logic             cfg_pec,
    output logic             rd_ready,
    output logic             rd_done,
    input  logic             rxq_pop,
    output logic [7:0]       rxq_data,
    output logic [LVL_W-1:0] rxq_level,
    output logic             rxq_ovf
);
    localparam int OCC_W = LVL_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RD_DEPTH);
    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(RXQ_DEPTH);

    smbt_cfg_t        cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ready_q, done_q, ovf_q;
    smbt_state_e      state_q, state_d;
    logic             hold_q, hold_d, cand_q, cand_d;
    logic [2:0][7:0]  stash_q, stash_d;
    logic [1:0]       stash_n, stash_n_d;
    logic             drain, app, kill, set_ovf, begin_rd, ack_c;
    logic             full, addr_hit;
    logic [OCC_W-1:0] occ;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic             eng_take, eng_finish, eng_abort;

    // ---------------- staging memory and reply engine ----------------
    smbt_rdbuf #(.DEPTH(RD_DEPTH), .IDX_W(IDX_W)) u_rdbuf (
        .clk   (clk),
        .rst   (rst),
        .we    (buf_we),
        .widx  (buf_idx),
        .wdata (buf_wdata),
        .ridx  (rd_idx),
        .rdata (rd_data)
    );

    assign eng_take = tx_take && (state_q == ST_READ);

    smbt_reply #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_reply (
        .clk      (clk),
        .rst      (rst),
        .begin_rd (begin_rd),
        .seed     (pec_seed(cfg_q.addr, cfg_q.cmd)),
        .cnt      (cnt_q),
        .pec_en   (cfg_q.pec),
        .take     (eng_take),
        .mack     (tx_mack),
        .buf_data (rd_data),
        .buf_idx  (rd_idx),
        .tx_byte  (tx_byte),
        .finish   (eng_finish),
        .abort    (eng_abort)
    );

    // ---------------- receive queue ----------------
    assign drain = !hold_q && (stash_n != 2'd0);

    smbt_rx_fifo #(.DEPTH(RXQ_DEPTH), .LVL_W(LVL_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (drain),
        .push_data (stash_q[0]),
        .pop       (rxq_pop),
        .pop_data  (rxq_data),
        .level     (rxq_level)
    );

    assign occ      = OCC_W'(rxq_level) + OCC_W'(stash_n);
    assign full     = (occ >= OCC_FULL);
    assign addr_hit = (rx_byte[7:1] == cfg_q.addr);

    // ---------------- transaction control ----------------
    always_comb begin
        ack_c    = 1'b0;
        app      = 1'b0;
        kill     = 1'b0;
        set_ovf  = 1'b0;
        begin_rd = 1'b0;
        state_d  = state_q;
        hold_d   = hold_q;
        cand_d   = cand_q;
        if (bus_stop) begin
            state_d = ST_IDLE;
            hold_d  = 1'b0;
            cand_d  = 1'b0;
        end else if (bus_start) begin
            state_d = ST_ADDR;
            cand_d  = (state_q == ST_MATCH);
            if (state_q != ST_MATCH) hold_d = 1'b0;
        end else if (rx_vld) begin
            case (state_q)
                ST_ADDR: begin
                    if (rx_byte[0]) begin
                        if (cand_q && ready_q && addr_hit) begin
                            ack_c    = 1'b1;
                            kill     = 1'b1;
                            begin_rd = 1'b1;
                            hold_d   = 1'b0;
                            cand_d   = 1'b0;
                            state_d  = ST_READ;
                        end else begin
                            hold_d  = 1'b0;
                            cand_d  = 1'b0;
                            state_d = ST_SKIP;
                        end
                    end else if (full) begin
                        set_ovf = 1'b1;
                        hold_d  = 1'b0;
                        cand_d  = 1'b0;
                        state_d = ST_SKIP;
                    end else begin
                        ack_c  = 1'b1;
                        app    = 1'b1;
                        cand_d = 1'b0;
                        if (!cand_q && ready_q && addr_hit) begin
                            hold_d  = 1'b1;
                            state_d = ST_CAND;
                        end else begin
                            hold_d  = 1'b0;
                            state_d = ST_WDATA;
                        end
                    end
                end
                ST_CAND, ST_MATCH, ST_WDATA: begin
                    if (full) begin
                        set_ovf = 1'b1;
                        hold_d  = 1'b0;
                        state_d = ST_SKIP;
                    end else begin
                        ack_c = 1'b1;
                        app   = 1'b1;
                        if (state_q == ST_CAND && rx_byte == cfg_q.cmd) begin
                            state_d = ST_MATCH;
                        end else begin
                            hold_d  = 1'b0;
                            state_d = ST_WDATA;
                        end
                    end
                end
                default: ;
            endcase
        end else if (eng_finish || eng_abort) begin
            state_d = ST_SKIP;
        end
    end

    assign rx_ack = ack_c;

    // ---------------- hold-back stash ----------------
    always_comb begin
        stash_d   = stash_q;
        stash_n_d = stash_n;
        if (drain) begin
            stash_d[0] = stash_q[1];
            stash_d[1] = stash_q[2];
            stash_n_d  = stash_n - 2'd1;
        end
        if (app) begin
            case (stash_n_d)
                2'd0:    stash_d[0] = rx_byte;
                2'd1:    stash_d[1] = rx_byte;
                default: stash_d[2] = rx_byte;
            endcase
            if (stash_n_d != 2'd3) stash_n_d = stash_n_d + 2'd1;
        end
        if (kill) stash_n_d = 2'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hold_q  <= 1'b0;
            cand_q  <= 1'b0;
            stash_q <= '0;
            stash_n <= 2'd0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            cand_q  <= cand_d;
            stash_q <= stash_d;
            stash_n <= stash_n_d;
        end
    end

    // ---------------- configuration and flags ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cnt_q   <= '0;
            ready_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (cfg_we) begin
            cfg_q   <= '{addr: cfg_addr, cmd: cfg_cmd, pec: cfg_pec};
            cnt_q   <= (cfg_cnt > CNT_MAX) ? CNT_MAX : cfg_cnt;
            ready_q <= 1'b1;
            done_q  <= 1'b0;
        end else if (eng_finish) begin
            ready_q <= 1'b0;
            done_q  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ovf_q <= 1'b0;
        else if (set_ovf) ovf_q <= 1'b1;
        else if (rxq_pop) ovf_q <= 1'b0;
    end

    assign rd_ready = ready_q;
    assign rd_done  = done_q;
    assign rxq_ovf  = ovf_q;
endmodule

// File: rtl/smbt_chk.sv
module smbt_chk
    import smbt_pkg::*;
#(
    parameter int RXQ_DEPTH = 240,
    parameter int CNT_W     = 6,
    parameter int LVL_W     = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_vld,
    input logic [7:0]       rx_byte,
    input logic             rx_ack,
    input logic [7:0]       tx_byte,
    input logic             rd_ready,
    input logic             rd_done,
    input logic [LVL_W-1:0] rxq_level,
    input logic             rxq_ovf,
    input smbt_state_e      state_q,
    input logic [6:0]       tgt_addr,
    input logic [CNT_W-1:0] cnt_q
);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(RXQ_DEPTH);

    AST_RXQ_BOUND: assert property (@(posedge clk) disable iff (rst)
        rxq_level <= LVL_FULL); // R9

    AST_NACK_AT_FULL: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && rxq_level == LVL_FULL) |-> !rx_ack); // R9

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rxq_ovf) |-> $past(rx_vld && !rx_ack)); // R9

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        rxq_level <= $past(rxq_level) + 1'b1); // R7

    AST_READ_GRANT: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && state_q == ST_ADDR && rx_byte[0] && rx_ack)
            |-> (rd_ready && rx_byte[7:1] == tgt_addr)); // R5

    AST_COUNT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && state_q == ST_ADDR && rx_byte[0] && rx_ack)
            |=> (tx_byte == 8'(cnt_q))); // R3

    AST_DONE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_done) |-> !rd_ready); // R6

    AST_SKIP_NACKS: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && state_q == ST_SKIP) |-> !rx_ack); // R10
endmodule

bind smbus_blkrd_target smbt_chk #(
    .RXQ_DEPTH (RXQ_DEPTH),
    .CNT_W     (CNT_W),
    .LVL_W     (LVL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_vld    (rx_vld),
    .rx_byte   (rx_byte),
    .rx_ack    (rx_ack),
    .tx_byte   (tx_byte),
    .rd_ready  (rd_ready),
    .rd_done   (rd_done),
    .rxq_level (rxq_level),
    .rxq_ovf   (rxq_ovf),
    .state_q   (state_q),
    .tgt_addr  (cfg_q.addr),
    .cnt_q     (cnt_q)
);

// File: tb/smbus_blkrd_target_tb.sv
`timescale 1ns/1ps
module smbus_blkrd_target_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_start = 0, bus_stop = 0, rx_vld = 0;
    logic [7:0] rx_byte = 0;
    logic       rx_ack;
    logic [7:0] tx_byte;
    logic       tx_take = 0, tx_mack = 0;
    logic       buf_we = 0;
    logic [4:0] buf_idx = 0;
    logic [7:0] buf_wdata = 0;
    logic       cfg_we = 0;
    logic [6:0] cfg_addr = 0;
    logic [7:0] cfg_cmd = 0;
    logic [5:0] cfg_cnt = 0;
    logic       cfg_pec = 0;
    logic       rd_ready, rd_done;
    logic       rxq_pop = 0;
    logic [7:0] rxq_data;
    logic [7:0] rxq_level;
    logic       rxq_ovf;

    always #2.5 clk = ~clk;

    smbus_blkrd_target u_dut (.*);

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    logic [7:0] m_data [32];
    logic [6:0] m_addr;
    logic [7:0] m_cmd;
    int         m_cnt;
    bit         m_pec;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic bus_ev(input bit is_start);
        @(negedge clk); bus_start = is_start; bus_stop = !is_start;
        @(negedge clk); bus_start = 0; bus_stop = 0;
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        @(negedge clk); rx_vld = 1; rx_byte = b;
        #1 ack = rx_ack;
        @(negedge clk); rx_vld = 0;
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] b);
        @(negedge clk); b = tx_byte; tx_take = 1; tx_mack = mack;
        @(negedge clk); tx_take = 0; tx_mack = 0;
    endtask

    task automatic fw_setup(input logic [6:0] a, input logic [7:0] c,
                            input int cnt, input bit pec);
        for (int i = 0; i < 32; i++) begin
            m_data[i] = 8'($urandom);
            @(negedge clk); buf_we = 1; buf_idx = 5'(i); buf_wdata = m_data[i];
        end
        @(negedge clk); buf_we = 0;
        cfg_we = 1; cfg_addr = a; cfg_cmd = c; cfg_cnt = 6'(cnt); cfg_pec = pec;
        @(negedge clk); cfg_we = 0;
        m_addr = a; m_cmd = c; m_pec = pec;
        m_cnt = (cnt > 32) ? 32 : cnt;
        chk(rd_ready == 1, "R2", "ready after config", rd_ready, 1);
        chk(rd_done == 0, "R2", "done cleared by config", rd_done, 0);
    endtask

    // raw byte: acked and queued only when room
    task automatic raw_byte(input logic [7:0] b, inout bit refused, input string tag);
        bit a;
        bit want;
        want = !refused && (exp_q.size() < 240);
        put_byte(b, a);
        chk(a == want, tag, "raw byte ack", a, want);
        if (want) exp_q.push_back(b); else refused = 1;
    endtask

    task automatic drain_chk(input string tag);
        repeat (6) @(negedge clk);
        chk(rxq_level == 8'(exp_q.size()), tag, "queue level", rxq_level, exp_q.size());
        while (exp_q.size() > 0 && rxq_level != 0) begin
            @(negedge clk);
            chk(rxq_data == exp_q[0], tag, "queue byte", rxq_data, exp_q[0]);
            void'(exp_q.pop_front());
            rxq_pop = 1;
            @(negedge clk); rxq_pop = 0;
        end
        while (rxq_level != 0) begin
            @(negedge clk); rxq_pop = 1;
            @(negedge clk); rxq_pop = 0;
        end
        exp_q.delete();
    endtask

    // full hardware read; nack_first: master NACKs the count byte
    task automatic blk_read(input bit nack_first);
        bit a;
        logic [7:0] b, crc, e;
        int total;
        bus_ev(1);
        put_byte({m_addr, 1'b0}, a);
        chk(a == 1, "R7", "candidate address ack", a, 1);
        put_byte(m_cmd, a);
        chk(a == 1, "R7", "candidate command ack", a, 1);
        bus_ev(1);
        put_byte({m_addr, 1'b1}, a);
        chk(a == 1, "R3", "read address ack", a, 1);
        crc = ref_crc(ref_crc(ref_crc(8'h00, {m_addr, 1'b0}), m_cmd), {m_addr, 1'b1});
        total = nack_first ? 1 : 1 + m_cnt + int'(m_pec);
        for (int i = 0; i < total; i++) begin
            if (i == 0) e = 8'(m_cnt);
            else if (i <= m_cnt) e = m_data[i-1];
            else e = crc;
            get_byte(!(i == total - 1), b);
            if (i <= m_cnt) chk(b == e, "R3", "reply byte", b, e);
            else chk(b == e, "R4", "PEC byte", b, e);
            crc = ref_crc(crc, b);
        end
        bus_ev(0);
        @(negedge clk);
        if (nack_first) begin
            chk(rd_ready == 1, "R6", "ready kept on early NACK", rd_ready, 1);
            chk(rd_done == 0, "R6", "no done on early NACK", rd_done, 0);
        end else begin
            chk(rd_ready == 0, "R6", "ready cleared at end", rd_ready, 0);
            chk(rd_done == 1, "R6", "done raised at end", rd_done, 1);
        end
    endtask

    initial begin
        bit a, refused;
        logic [6:0] oa;
        int kind, len;
        void'($urandom(32'd7781));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(rd_ready == 0, "R1", "ready after reset", rd_ready, 0);
        chk(rd_done == 0, "R1", "done after reset", rd_done, 0);
        chk(rxq_level == 0, "R1", "level after reset", rxq_level, 0);
        chk(rxq_ovf == 0, "R1", "ovf after reset", rxq_ovf, 0);

        // R5: read with ready clear -> NACK; preamble is plain raw data
        m_addr = 7'h2B; m_cmd = 8'h91;
        bus_ev(1);
        refused = 0;
        raw_byte({m_addr, 1'b0}, refused, "R5");
        raw_byte(m_cmd, refused, "R5");
        bus_ev(1);
        put_byte({m_addr, 1'b1}, a);
        chk(a == 0, "R5", "read NACK when not armed", a, 0);
        put_byte(8'h55, a);
        chk(a == 0, "R10", "byte after NACK refused", a, 0);
        bus_ev(0);
        drain_chk("R10");

        // R2 clamp, R4 PEC, R6 early NACK then complete
        fw_setup(7'h2B, 8'h91, 45, 1);
        blk_read(1);
        blk_read(0);
        drain_chk("R8");
        // after completion: not armed, read refused
        bus_ev(1);
        refused = 0;
        raw_byte({m_addr, 1'b0}, refused, "R5");
        raw_byte(m_cmd, refused, "R5");
        bus_ev(1);
        put_byte({m_addr, 1'b1}, a);
        chk(a == 0, "R5", "read NACK after completion", a, 0);
        bus_ev(0);
        drain_chk("R5");

        // count 0 with and without PEC
        fw_setup(7'h11, 8'h00, 0, 0);
        blk_read(0);
        fw_setup(7'h11, 8'h00, 0, 1);
        blk_read(0);
        drain_chk("R8");

        // constrained random transactions
        for (int it = 0; it < 40; it++) begin
            fw_setup(7'($urandom_range(8, 119)), 8'($urandom), $urandom_range(0, 40),
                     1'($urandom_range(0, 1)));
            kind = $urandom_range(0, 3);
            refused = 0;
            case (kind)
                0: blk_read(0);
                1: begin
                    oa = m_addr ^ 7'($urandom_range(1, 127));
                    len = $urandom_range(0, 6);
                    bus_ev(1);
                    raw_byte({oa, 1'b0}, refused, "R7");
                    for (int j = 0; j < len; j++) raw_byte(8'($urandom), refused, "R7");
                    bus_ev(1);
                    put_byte({oa, 1'b1}, a);
                    chk(a == 0, "R5", "read of other address NACK", a, 0);
                    bus_ev(0);
                end
                2: begin
                    len = $urandom_range(0, 3);
                    bus_ev(1);
                    raw_byte({m_addr, 1'b0}, refused, "R8");
                    raw_byte(m_cmd, refused, "R8");
                    for (int j = 0; j < len; j++) raw_byte(8'($urandom), refused, "R8");
                    bus_ev(0);
                    drain_chk("R8");
                    blk_read(0);
                end
                default: begin
                    bus_ev(1);
                    raw_byte({m_addr, 1'b0}, refused, "R8");
                    raw_byte(m_cmd ^ 8'h01, refused, "R8");
                    bus_ev(1);
                    put_byte({m_addr, 1'b1}, a);
                    chk(a == 0, "R5", "read after wrong command NACK", a, 0);
                    put_byte(8'hA5, a);
                    chk(a == 0, "R10", "byte after NACK refused", a, 0);
                    bus_ev(0);
                end
            endcase
            drain_chk("R7");
        end

        // R9 overflow: address + 245 data bytes without pops
        fw_setup(7'h40, 8'h12, 4, 0);
        bus_ev(1);
        refused = 0;
        raw_byte({7'h41, 1'b0}, refused, "R9");
        for (int j = 0; j < 245; j++) raw_byte(8'(j * 7 + 3), refused, "R9");
        bus_ev(0);
        repeat (4) @(negedge clk);
        chk(rxq_ovf == 1, "R9", "overflow flag set", rxq_ovf, 1);
        chk(rxq_level == 8'd240, "R9", "level at capacity", rxq_level, 240);
        @(negedge clk);
        chk(rxq_data == exp_q[0], "R9", "head byte", rxq_data, exp_q[0]);
        void'(exp_q.pop_front());
        rxq_pop = 1;
        @(negedge clk); rxq_pop = 0;
        chk(rxq_ovf == 0, "R9", "pop clears overflow", rxq_ovf, 0);
        chk(rxq_level == 8'd239, "R9", "level after pop", rxq_level, 239);
        drain_chk("R9");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule